// File: doc/BRIEF.md
# Qualified PLL Lock Detector

This block watches the error pulse of a PLL phase detector and decides whether the loop is locked. A fast sampling clock counts how many of its cycles the error pulse is high within each compare cycle. A compare-cycle strobe marks the boundary between compare cycles. When the strobe arrives, the measured width is compared with a programmable threshold. A width below the threshold counts as a good cycle, and a width at or above it counts as a bad cycle.

A qualification counter filters these verdicts unevenly. It raises the lock indicator only after eight good compare cycles in a row, and it drops the indicator after one bad cycle. If the reference stops, the strobe stops too. A programmable timeout turns that silence into a bad cycle, so lock still falls. An active-low clear input restarts the whole detector. The error pulse is asynchronous and passes through a two-flop synchronizer before it is measured.

Top module: `pll_lock_qualifier`

## Requirements
- R1: While reset is applied, and after reset is released, the lock output is low and the qualification count is zero.
- R2: The lock output rises only after eight consecutive good compare cycles. It is visible in the cycle after the eighth strobe, and seven good cycles are not enough.
- R3: A single bad compare cycle drops the lock output in the cycle after its strobe and restarts the count. Eight further good cycles are then needed before lock returns.
- R4: While clr_n is low, the lock output is low and the count, the width window and the timeout counter are held at zero. Strobes that arrive during the clear are not counted.
- R5: The measured width is the number of sampling clock cycles in which the synchronized error pulse is high. The synchronized pulse lags err_pulse by two cycles. The sample taken in a strobe cycle belongs to the new window.
- R6: If tmo_lim is non-zero and no strobe arrives in the tmo_lim cycles after the last strobe or timeout, a bad cycle is recorded. A strobe that arrives exactly in that cycle takes precedence over the timeout. A tmo_lim of zero disables the timeout.
- R7: The width count saturates at 2^WIDTH_W-1 and does not wrap. A window of 300 high samples with a threshold of 255 is bad.
- R8: A width equal to the threshold is bad and a width one below it is good. A threshold of zero makes every compare cycle bad.
- R9: While good compare cycles continue, the lock output stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clr_n | input | 1 | Active-low synchronous clear of the detector |
| cmp_stb | input | 1 | One-cycle strobe that closes each compare cycle |
| err_pulse | input | 1 | Asynchronous phase detector error pulse |
| thresh | input | WIDTH_W | Width threshold in sampling clock cycles; a width at or above it is bad |
| tmo_lim | input | TMO_W | Strobe timeout in sampling clock cycles; 0 disables the timeout |
| lock | output | 1 | Qualified lock indicator |

## Verification
The strobe and the timeout expiry can fall in the same cycle. The bench provokes this by sending strobes exactly every tmo_lim cycles. The judgment is that lock is still reached after eight strobes, which shows the strobe took precedence. With a period one cycle longer than tmo_lim, every gap times out and lock must never appear. A clear that coincides with a strobe and a window whose last synchronized high sample lands in the strobe cycle are provoked the same way. Both are judged against a cycle model in the bench that is built from the requirements.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
  typedef struct packed {
    logic good;
    logic bad;
  } verdict_t;
endpackage

// File: rtl/lock_err_sync.sv
module lock_err_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/lock_width_meter.sv
module lock_width_meter
  import pll_lock_pkg::*;
#(
  parameter int WIDTH_W = 8,
  parameter int TMO_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_n,
  input  logic               cmp_stb,
  input  logic               err_s,
  input  logic [WIDTH_W-1:0] thresh,
  input  logic [TMO_W-1:0]   tmo_lim,
  output verdict_t           vd
);
  localparam logic [WIDTH_W-1:0] WMAX = '1;
  localparam logic [TMO_W-1:0]   IMAX = '1;

  logic [WIDTH_W-1:0] wid_q, wid_d;
  logic [TMO_W-1:0]   idle_q, idle_d;
  logic               tmo;

  always_comb begin
    tmo = clr_n && !cmp_stb && (tmo_lim != '0) &&
          (idle_q == tmo_lim - TMO_W'(1));
    vd.good = clr_n && cmp_stb && (wid_q < thresh);
    vd.bad  = clr_n && ((cmp_stb && (wid_q >= thresh)) || tmo);

    if (!clr_n)                      wid_d = '0;
    else if (cmp_stb)                wid_d = {{(WIDTH_W-1){1'b0}}, err_s};
    else if (err_s && wid_q != WMAX) wid_d = wid_q + WIDTH_W'(1);
    else                             wid_d = wid_q;

    if (!clr_n || cmp_stb || tmo)    idle_d = '0;
    else if (idle_q != IMAX)         idle_d = idle_q + TMO_W'(1);
    else                             idle_d = idle_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wid_q  <= '0;
      idle_q <= '0;
    end else begin
      wid_q  <= wid_d;
      idle_q <= idle_d;
    end
  end

  // R7: a full width count holds while more high samples arrive
  p_width_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !cmp_stb && err_s && wid_q == WMAX) |=> (wid_q == WMAX));
  // R6: a bad verdict without a strobe needs an enabled timeout
  p_tmo_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vd.bad && !cmp_stb) |-> (tmo_lim != '0));
  // R4: clear empties the width window
  p_clear_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (wid_q == '0 && idle_q == '0));
endmodule

// File: rtl/lock_qualifier.sv
module lock_qualifier
  import pll_lock_pkg::*;
#(
  parameter int QUAL = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr_n,
  input  verdict_t vd,
  output logic     lock
);
  localparam int QW = $clog2(QUAL + 1);
  localparam logic [QW-1:0] QFULL = QW'(QUAL);

  logic [QW-1:0] cnt_q, cnt_d;
  logic          lock_q, lock_d;

  always_comb begin
    if (!clr_n || vd.bad)            cnt_d = '0;
    else if (vd.good && cnt_q != QFULL) cnt_d = cnt_q + QW'(1);
    else                             cnt_d = cnt_q;
    lock_d = (cnt_d == QFULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  assign lock = lock_q;

  // R3: one bad cycle withdraws lock and restarts qualification
  p_drop_on_bad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vd.bad |=> (!lock && cnt_q == '0));
  // R4: clear forces lock low and count to zero
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (!lock && cnt_q == '0));
  // R2: lock rises only on the last of the qualifying good cycles
  p_rise_after_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> ($past(vd.good) && $past(cnt_q) == QFULL - QW'(1)));
  // R8: a compare cycle is never both good and bad
  p_verdict_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(vd.good && vd.bad));
endmodule

// File: rtl/pll_lock_qualifier.sv
module pll_lock_qualifier
  import pll_lock_pkg::*;
#(
  parameter int WIDTH_W = 8,
  parameter int TMO_W   = 16,
  parameter int QUAL    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_n,
  input  logic               cmp_stb,
  input  logic               err_pulse,
  input  logic [WIDTH_W-1:0] thresh,
  input  logic [TMO_W-1:0]   tmo_lim,
  output logic               lock
);
  logic [1:0] rst_sh_q;
  logic       rst_s_n;
  logic       err_s;
  verdict_t   vd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_s_n = rst_sh_q[1];

  lock_err_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .d(err_pulse), .q(err_s)
  );

  lock_width_meter #(.WIDTH_W(WIDTH_W), .TMO_W(TMO_W)) u_meter (
    .clk(clk), .rst_n(rst_s_n), .clr_n(clr_n), .cmp_stb(cmp_stb),
    .err_s(err_s), .thresh(thresh), .tmo_lim(tmo_lim), .vd(vd)
  );

  lock_qualifier #(.QUAL(QUAL)) u_qual (
    .clk(clk), .rst_n(rst_s_n), .clr_n(clr_n), .vd(vd), .lock(lock)
  );

  // R1: lock is low whenever the internal reset is held
  p_reset_low_r1: assert property (@(posedge clk) !rst_s_n |=> !lock);
endmodule

// File: tb/pll_lock_qualifier_bench.sv
module pll_lock_qualifier_bench;
  logic        clk = 1'b0;
  logic        rst_n, clr_n, cmp_stb, err_pulse;
  logic [7:0]  thresh;
  logic [15:0] tmo_lim;
  logic        lock;

  int total = 0;
  int bad = 0;
  bit model_on = 0;

  int m_s1, m_s2, m_w, m_i, m_q;
  bit m_lock;

  always #10 clk = ~clk;

  pll_lock_qualifier u_pll_lock_qualifier (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cmp_stb(cmp_stb),
    .err_pulse(err_pulse), .thresh(thresh), .tmo_lim(tmo_lim), .lock(lock)
  );

  function automatic int sat_inc(int v, int mx);
    return (v >= mx) ? mx : v + 1;
  endfunction

  // cycle model built from the requirements
  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_w = 0; m_i = 0; m_q = 0; m_lock = 0;
    end else begin
      int es;
      bit tmo, gd, bd;
      es = m_s2; m_s2 = m_s1; m_s1 = int'(err_pulse);
      if (!clr_n) begin
        m_w = 0; m_i = 0; m_q = 0;
      end else begin
        tmo = !cmp_stb && tmo_lim != 0 && m_i == int'(tmo_lim) - 1;
        gd = cmp_stb && m_w < int'(thresh);
        bd = (cmp_stb && m_w >= int'(thresh)) || tmo;
        if (cmp_stb) m_w = es;
        else if (es == 1) m_w = sat_inc(m_w, 255);
        if (cmp_stb || tmo) m_i = 0; else m_i = sat_inc(m_i, 65535);
        if (bd) m_q = 0; else if (gd) m_q = sat_inc(m_q, 8);
      end
      m_lock = (m_q == 8);
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: lock=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (model_on) chk("R2 R3 R6 model", lock, m_lock);

  task automatic cyc(input logic s, input logic e);
    cmp_stb = s; err_pulse = e;
    @(negedge clk);
  endtask

  task automatic win(input int hi);
    repeat (hi) cyc(0, 1);
    repeat (3) cyc(0, 0);
    cyc(1, 0);
  endtask

  task automatic qualify(input int hi);
    repeat (8) win(hi);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    rst_n = 0; clr_n = 0; cmp_stb = 0; err_pulse = 0;
    thresh = 8'd10; tmo_lim = 16'd0;
    repeat (4) @(negedge clk);
    chk("R1 in reset", lock, 1'b0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    model_on = 1;
    clr_n = 1;
    cyc(0, 0);
    chk("R1 after reset", lock, 1'b0);

    // R2: seven good cycles not enough, eighth grants lock
    repeat (7) win(5);
    chk("R2 seven good", lock, 1'b0);
    win(5);
    chk("R2 eighth good", lock, 1'b1);
    repeat (4) win(9);
    chk("R9 lock held", lock, 1'b1);

    // R8 / R3: width equal to threshold is bad, relock needs eight
    win(10);
    chk("R8 width equals thresh", lock, 1'b0);
    repeat (7) win(3);
    chk("R3 restart seven", lock, 1'b0);
    win(3);
    chk("R3 restart eighth", lock, 1'b1);

    // R4: clear drops lock, strobes ignored while low
    clr_n = 0;
    cyc(1, 0); cyc(0, 1); cyc(1, 0); cyc(1, 1); cyc(0, 0);
    chk("R4 clear low", lock, 1'b0);
    clr_n = 1;
    repeat (7) win(0);
    chk("R4 clear restarted count", lock, 1'b0);
    win(0);
    chk("R4 relock after clear", lock, 1'b1);

    // R5: sync delay and window boundary
    thresh = 8'd4;
    qualify(0);
    repeat (4) cyc(0, 1);
    cyc(0, 0);
    cyc(1, 0);
    chk("R5 last sample in new window", lock, 1'b1);
    win(3);
    chk("R5 carried sample counted", lock, 1'b0);

    // R7: saturation, R8 boundary below threshold
    thresh = 8'd255;
    qualify(0);
    chk("R7 relock at 255", lock, 1'b1);
    win(254);
    chk("R8 width one below thresh", lock, 1'b1);
    win(300);
    chk("R7 saturated width is bad", lock, 1'b0);
    thresh = 8'd0;
    win(0);
    chk("R8 zero threshold bad", lock, 1'b0);

    // R6: timeout, coincidence with strobe, disable
    thresh = 8'd10;
    tmo_lim = 16'd20;
    qualify(0);
    chk("R6 lock before idle", lock, 1'b1);
    repeat (25) cyc(0, 0);
    chk("R6 timeout drops lock", lock, 1'b0);
    tmo_lim = 16'd8;
    repeat (9) begin cyc(1, 0); repeat (7) cyc(0, 0); end
    chk("R6 strobe wins over timeout", lock, 1'b1);
    tmo_lim = 16'd7;
    repeat (9) begin cyc(1, 0); repeat (7) cyc(0, 0); end
    chk("R6 period beyond timeout", lock, 1'b0);
    tmo_lim = 16'd0;
    qualify(0);
    repeat (100) cyc(0, 0);
    chk("R6 timeout disabled", lock, 1'b1);

    // random phase, checked by the cycle model every cycle
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 199) == 0) thresh = 8'($urandom_range(0, 12));
      if ($urandom_range(0, 299) == 0)
        tmo_lim = ($urandom_range(0, 2) == 0) ? 16'd0 : 16'($urandom_range(5, 30));
      clr_n = ($urandom_range(0, 149) != 0);
      cyc($urandom_range(0, 5) == 0, $urandom_range(0, 3) == 0);
    end

    model_on = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule